// File: doc/BRIEF.md
# Level-Matched Interrupt Responder with Daisy-Chain Arbitration

This block is the interrupt front end of a peripheral module that contains several submodules able to raise interrupts. Each submodule has a 3-bit priority level and a request pulse. The block latches requests as pending flags. It drives the highest pending, enabled level onto the shared interconnect as the module's request level. When the interconnect runs an acknowledge cycle with a level, the block joins only if that level equals its own request level.

On a match, the block takes a snapshot of its submodules that are pending at the acknowledged level. Once the inter-module grant input is asserted, a fixed daisy chain picks the snapshot member with the lowest index. The block then drives that source's unique 8-bit vector for exactly one cycle and clears that source's pending flag. Some source slots are built without interrupt capability, and they never request.

The controller has four states. IDLE waits for an acknowledge. ARB holds a matched snapshot and waits for the grant. SEND drives the vector. DONE waits for the acknowledge to end. The transitions are:
- IDLE→ARB on a level match.
- IDLE→DONE on an acknowledge that does not match.
- ARB→SEND when the grant arrives and the snapshot has a member.
- ARB→DONE when the grant arrives and the snapshot is empty.
- ARB→IDLE when the acknowledge ends without a grant.
- SEND→DONE if the acknowledge is still active, or SEND→IDLE if it is not.
- DONE→IDLE when the acknowledge ends.

Top module: `irq_level_responder`

## Requirements
- R1: After reset, `req_level` is 0, `vec_valid` is 0 and `vec_out` is 0, and no source is pending.
- R2: `req_level` equals the highest `src_level` among pending sources whose level is nonzero, or 0 when there is none. Source i's level is `src_level[3*i+2:3*i]`.
- R3: A request pulse from a source whose level is 0 at that moment is dropped. Raising the level later does not make the source pending.
- R4: Requests from source slots whose bit in the capability mask parameter is 0 never become pending. The default mask is 6'b111101, so source 1 is incapable.
- R5: An acknowledge whose level differs from `req_level` produces no vector and leaves all pending flags unchanged.
- R6: For a matched acknowledge, the cycle after the grant is sampled high in ARB, `vec_valid` is 1 for exactly one cycle. During that cycle `vec_out` = VEC_BASE + winner index, with VEC_BASE defaulting to 8'h40. At all other times `vec_out` is 0.
- R7: Among snapshot members, the lowest source index wins.
- R8: The winner's pending flag clears at the end of the vector cycle. All other pending flags are kept.
- R9: An acknowledge that ends without a grant produces no vector and keeps all pending flags.
- R10: A request arriving after the match edge of an acknowledge becomes pending but does not compete in that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | One-cycle request pulse per source |
| src_level | input | 3*NUM_SRC | Priority level per source, 0 = disabled |
| ack_valid | input | 1 | Acknowledge cycle active on the interconnect |
| ack_level | input | 3 | Level being acknowledged |
| grant | input | 1 | Inter-module arbitration won |
| req_level | output | 3 | Module request level driven to the interconnect |
| vec_valid | output | 1 | Vector on `vec_out` is valid |
| vec_out | output | 8 | Vector of the serviced source |

## Verification
A request pulse sampled at edge k shows on `req_level` just after edge k, because the level is derived combinationally from the pending flags. For an acknowledge, the match is taken at edge k and the grant is sampled at edge k+1. The vector is therefore visible just after edge k+1, and the pending clear and the drop of `vec_valid` are visible just after edge k+2. The bench drives inputs on falling edges and samples 1 ns after the rising edge on which each result is due. It reads the vector in the first cycle and the cleared state in the second.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARB  = 2'd1,
        S_SEND = 2'd2,
        S_DONE = 2'd3
    } resp_state_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int          NUM_SRC = 6,
    parameter int          LVL_W   = 3,
    parameter logic [NUM_SRC-1:0] CAN_IRQ = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       set_req,
    input  logic [NUM_SRC*LVL_W-1:0] src_level,
    input  logic [NUM_SRC-1:0]       clr,
    output logic [NUM_SRC-1:0]       pend
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            if (CAN_IRQ[gi]) begin : g_cap
                logic take;
                assign take = set_req[gi] && (src_level[gi*LVL_W +: LVL_W] != '0);

                always_ff @(posedge clk) begin
                    if (!rst_n)        pend[gi] <= 1'b0;
                    else if (take)     pend[gi] <= 1'b1;
                    else if (clr[gi])  pend[gi] <= 1'b0;
                end

                // R8: a clear without a simultaneous accepted request drops the flag
                p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr[gi] && !take) |=> !pend[gi]);
                // R3: a request at level 0 never raises the flag
                p_lvl0_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (!pend[gi] && set_req[gi] && src_level[gi*LVL_W +: LVL_W] == '0) |=> !pend[gi]);
            end else begin : g_nocap
                assign pend[gi] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_level_max.sv
module irq_level_max #(
    parameter int NUM_SRC = 6,
    parameter int LVL_W   = 3
) (
    input  logic [NUM_SRC-1:0]       live,
    input  logic [NUM_SRC*LVL_W-1:0] src_level,
    output logic [LVL_W-1:0]         lvl_max
);

    always_comb begin
        lvl_max = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (live[i] && (src_level[i*LVL_W +: LVL_W] > lvl_max))
                lvl_max = src_level[i*LVL_W +: LVL_W];
        end
    end

endmodule

// File: rtl/irq_chain_pick.sv
module irq_chain_pick #(
    parameter int NUM_SRC = 6,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cand,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // Walk from the tail to the head so the head-most candidate is kept last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // R7: the chosen source is a candidate
    p_pick_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[idx]);
    // R7: no candidate sits ahead of the chosen one in the chain
    p_pick_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((cand & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0));

endmodule

// File: rtl/irq_level_responder.sv
module irq_level_responder
    import irq_resp_pkg::*;
#(
    parameter int                 NUM_SRC  = 6,
    parameter int                 LVL_W    = 3,
    parameter int                 VEC_W    = 8,
    parameter logic [VEC_W-1:0]   VEC_BASE = 8'h40,
    parameter logic [NUM_SRC-1:0] CAN_IRQ  = 6'b111101
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*LVL_W-1:0] src_level,
    input  logic                     ack_valid,
    input  logic [LVL_W-1:0]         ack_level,
    input  logic                     grant,
    output logic [LVL_W-1:0]         req_level,
    output logic                     vec_valid,
    output logic [VEC_W-1:0]         vec_out
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    resp_state_e        state_q, state_d;
    logic [NUM_SRC-1:0] pend, lvl_on, live, at_ack, cand_q, clr;
    logic [IDX_W-1:0]   pick_idx, win_idx_q;
    logic               pick_found, match;

    irq_pend_bank #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .CAN_IRQ(CAN_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_req(src_req), .src_level(src_level),
        .clr(clr), .pend(pend)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_lvl
            assign lvl_on[gi] = (src_level[gi*LVL_W +: LVL_W] != '0);
            assign at_ack[gi] = (src_level[gi*LVL_W +: LVL_W] == ack_level);
        end
    endgenerate

    assign live = pend & lvl_on;

    irq_level_max #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_lmax (
        .live(live), .src_level(src_level), .lvl_max(req_level)
    );

    irq_chain_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .clk(clk), .rst_n(rst_n), .cand(cand_q), .found(pick_found), .idx(pick_idx)
    );

    assign match = ack_valid && (ack_level == req_level) && (req_level != '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (ack_valid) state_d = match ? S_ARB : S_DONE;
            S_ARB: begin
                if (!ack_valid)     state_d = S_IDLE;
                else if (grant)     state_d = pick_found ? S_SEND : S_DONE;
            end
            S_SEND: state_d = ack_valid ? S_DONE : S_IDLE;
            S_DONE: if (!ack_valid) state_d = S_IDLE;
        endcase
    end

    // State register plus the data captured on transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cand_q    <= '0;
            win_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && match)
                cand_q <= live & at_ack;
            if (state_q == S_ARB && state_d == S_SEND)
                win_idx_q <= pick_idx;
        end
    end

    // Outputs decoded from state
    always_comb begin
        vec_valid = 1'b0;
        vec_out   = '0;
        clr       = '0;
        unique case (state_q)
            S_SEND: begin
                vec_valid = 1'b1;
                vec_out   = VEC_BASE + VEC_W'(win_idx_q);
                clr       = NUM_SRC'(1) << win_idx_q;
            end
            S_IDLE, S_ARB, S_DONE: ;
        endcase
    end

    // R6: the vector lasts one cycle
    p_vec_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // R6: a vector follows a grant sampled during an acknowledge
    p_vec_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(grant && ack_valid));
    // R6: the vector names a real source
    p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (int'(vec_out) >= int'(VEC_BASE) &&
                       int'(vec_out) <  int'(VEC_BASE) + NUM_SRC));
    // R5: a mismatched acknowledge yields no vector in the next two cycles
    p_no_vec_mismatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && ack_valid && ack_level != req_level) |=> !vec_valid ##1 !vec_valid);

endmodule

// File: tb/irq_level_responder_bench.sv
module irq_level_responder_bench;

    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic [3*N-1:0] src_level = '0;
    logic         ack_valid = 1'b0;
    logic [2:0]   ack_level = '0;
    logic         grant = 1'b0;
    logic [2:0]   req_level;
    logic         vec_valid;
    logic [7:0]   vec_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_level_responder u_irq_level_responder (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_level(src_level),
        .ack_valid(ack_valid), .ack_level(ack_level), .grant(grant),
        .req_level(req_level), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic set_lvl(input int i, input logic [2:0] l);
        src_level[i*3 +: 3] = l;
    endtask

    task automatic pulse_req(input logic [N-1:0] m);
        @(negedge clk) src_req = m;
        @(negedge clk) src_req = '0;
    endtask

    task automatic do_ack(input logic [2:0] lvl, input bit give, input logic [N-1:0] mid,
                          output bit v, output int vec, output bit v_after);
        @(negedge clk) begin ack_valid = 1'b1; ack_level = lvl; grant = 1'b0; end
        @(negedge clk) begin grant = give; src_req = mid; end
        @(posedge clk); #1;
        v = vec_valid; vec = vec_out;
        @(negedge clk) begin ack_valid = 1'b0; grant = 1'b0; src_req = '0; end
        @(posedge clk); #1;
        v_after = vec_valid;
    endtask

    task automatic t_reset();
        chk("R1 req_level", req_level, 0);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 vec_out", vec_out, 0);
    endtask

    task automatic t_level_max();
        bit v, va; int vec;
        set_lvl(3, 3'd2); set_lvl(5, 3'd6);
        pulse_req(6'b101000);
        chk("R2 highest level", req_level, 6);
        do_ack(3'd6, 1'b1, '0, v, vec, va);
        chk("R6 vec_valid", v, 1);
        chk("R6 vector src5", vec, 8'h45);
        chk("R6 one cycle", va, 0);
        chk("R8 level after clear", req_level, 2);
        do_ack(3'd2, 1'b1, '0, v, vec, va);
        chk("R6 vector src3", vec, 8'h43);
        chk("R2 none pending", req_level, 0);
        set_lvl(3, 3'd0); set_lvl(5, 3'd0);
    endtask

    task automatic t_level_zero();
        set_lvl(4, 3'd0);
        pulse_req(6'b010000);
        set_lvl(4, 3'd3);
        @(posedge clk); #1;
        chk("R3 dropped at level 0", req_level, 0);
        set_lvl(4, 3'd0);
    endtask

    task automatic t_incapable();
        bit v, va; int vec;
        set_lvl(1, 3'd5);
        pulse_req(6'b000010);
        chk("R4 incapable no level", req_level, 0);
        do_ack(3'd5, 1'b1, '0, v, vec, va);
        chk("R4 incapable no vector", v, 0);
        set_lvl(1, 3'd0);
    endtask

    task automatic t_mismatch_and_nogrant();
        bit v, va; int vec;
        set_lvl(2, 3'd3);
        pulse_req(6'b000100);
        do_ack(3'd5, 1'b1, '0, v, vec, va);
        chk("R5 mismatch no vector", v, 0);
        chk("R5 mismatch kept", req_level, 3);
        do_ack(3'd3, 1'b0, '0, v, vec, va);
        chk("R9 no grant no vector", v, 0);
        chk("R9 no grant kept", req_level, 3);
        do_ack(3'd3, 1'b1, '0, v, vec, va);
        chk("R6 vector src2", vec, 8'h42);
        chk("R8 src2 cleared", req_level, 0);
        set_lvl(2, 3'd0);
    endtask

    task automatic t_chain();
        bit v, va; int vec;
        set_lvl(0, 3'd4); set_lvl(3, 3'd4); set_lvl(5, 3'd4);
        pulse_req(6'b101001);
        do_ack(3'd4, 1'b1, '0, v, vec, va);
        chk("R7 head wins src0", vec, 8'h40);
        chk("R8 others kept", req_level, 4);
        do_ack(3'd4, 1'b1, '0, v, vec, va);
        chk("R7 next src3", vec, 8'h43);
        do_ack(3'd4, 1'b1, '0, v, vec, va);
        chk("R7 tail src5", vec, 8'h45);
        chk("R8 all cleared", req_level, 0);
        set_lvl(3, 3'd0); set_lvl(5, 3'd0);
    endtask

    task automatic t_mid_request();
        bit v, va; int vec;
        set_lvl(0, 3'd4); set_lvl(2, 3'd4);
        pulse_req(6'b000100);
        do_ack(3'd4, 1'b1, 6'b000001, v, vec, va);
        chk("R10 late request excluded", vec, 8'h42);
        chk("R10 late request pending", req_level, 4);
        do_ack(3'd4, 1'b1, '0, v, vec, va);
        chk("R10 late request served next", vec, 8'h40);
        chk("R10 drained", req_level, 0);
        set_lvl(0, 3'd0); set_lvl(2, 3'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_level_max();
        t_level_zero();
        t_incapable();
        t_mismatch_and_nogrant();
        t_chain();
        t_mid_request();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule